// File: doc/BRIEF.md
# Subbanked Multi-Thread Register Array with Local Write Buffers

This block stores the architectural registers of several hardware threads in one shared array. The array is split into subbanks whose cells take many cycles to program. Each subbank has a one-entry local buffer. An accepted write is captured into that buffer in a single cycle. The shared request path is then free again, while the slow programming finishes inside the subbank. Writes are differential: the buffer keeps only the mask of bits that differ from the stored word. A write that changes nothing therefore never occupies its subbank.

Registers of one thread are striped across the subbanks, so consecutive register indices land in different subbanks. Reads use a separate read path. A read returns the new value from a pending buffer when the address matches. It stalls only when its subbank is busy with a write to a different row. Every accepted write also reports, one cycle later, how many bits it actually flips. The register count, thread count and subbank count are assumed to be powers of two.

Top module: `subbank_regfile`

## Requirements
- R1: A write is accepted (wr_ready high) whenever the subbank selected by its register index is idle. The address and data are captured in that single cycle.
- R2: An accepted write that changes at least one bit makes wr_ready low for every write to that subbank for exactly WRITE_CYCLES cycles after acceptance. After that, the new word is stored.
- R3: An accepted write whose data equals the stored word reports a flip count of 0 and leaves the subbank idle in the very next cycle.
- R4: One cycle after each accepted write, flip_valid pulses high and flip_count equals the number of bit positions in which the new data differs from the previously stored word.
- R5: One cycle after each accepted read, rd_data_valid pulses high with rd_data. In cycles without an accepted read, rd_data_valid is low.
- R6: A read whose thread and index match a write still pending in its subbank returns the pending new data, not the old stored word.
- R7: A read to a subbank busy with a write to a different row is stalled: rd_ready is low until that write retires.
- R8: A write in progress in one subbank never lowers rd_ready for a read addressed to another subbank.
- R9: Register r of thread t is held in subbank r mod NUM_SUBBANKS, at row t*(NUM_REGS/NUM_SUBBANKS) + r/NUM_SUBBANKS. The row determines which reads stall (R7), and a read returns the word last written to the same thread and index.
- R10: Synchronous active-high reset sets every buffer idle, clears all words to zero, and holds rd_data_valid and flip_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Target subbank can take the write |
| wr_tid | input | $clog2(NUM_THREADS) | Thread of the write |
| wr_idx | input | $clog2(NUM_REGS) | Register index of the write |
| wr_data | input | DATA_W | New register value |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read can be taken this cycle |
| rd_tid | input | $clog2(NUM_THREADS) | Thread of the read |
| rd_idx | input | $clog2(NUM_REGS) | Register index of the read |
| rd_data | output | DATA_W | Read result |
| rd_data_valid | output | 1 | rd_data belongs to the read accepted one cycle earlier |
| flip_valid | output | 1 | flip_count belongs to the write accepted one cycle earlier |
| flip_count | output | $clog2(DATA_W+1) | Number of bits that write programs |

## Verification
The ready outputs are combinational, so the bench compares wr_ready and rd_ready in the same cycle the request is driven, against the reference model's busy counters. rd_data, rd_data_valid, flip_valid and flip_count are due one clock edge after acceptance, so they are sampled on the following falling edge. A changing write blocks its subbank for WRITE_CYCLES edges. The model counts these edges down in step with the clock, so the cycle when ready returns and the stored word becomes visible are predicted exactly. Zero-change writes, forwarded reads and cross-subbank reads are forced in a directed phase before random traffic.

// File: rtl/subbank_regfile_pkg.sv
package subbank_regfile_pkg;
    typedef enum logic {
        SB_IDLE = 1'b0,
        SB_PROG = 1'b1
    } sb_state_e;
endpackage

// File: rtl/srf_addr_map.sv
// Stripes a thread's registers across subbanks: low index bits pick the
// subbank, thread id and remaining index bits form the row.
module srf_addr_map #(
    parameter int NUM_SUBBANKS = 4,
    parameter int NUM_THREADS  = 4,
    parameter int NUM_REGS     = 32
) (
    input  logic [$clog2(NUM_THREADS)-1:0]                                        tid,
    input  logic [$clog2(NUM_REGS)-1:0]                                           idx,
    output logic [$clog2(NUM_SUBBANKS)-1:0]                                       sb,
    output logic [$clog2(NUM_THREADS)+$clog2(NUM_REGS)-$clog2(NUM_SUBBANKS)-1:0] row
);
    localparam int SB_W  = $clog2(NUM_SUBBANKS);
    localparam int IDX_W = $clog2(NUM_REGS);

    always_comb begin
        sb  = idx[SB_W-1:0];
        row = {tid, idx[IDX_W-1:SB_W]};
    end
endmodule

// File: rtl/srf_popcount.sv
module srf_popcount #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/srf_subbank.sv
// One subbank: behavioural storage plus a one-entry differential write buffer.
module srf_subbank
    import subbank_regfile_pkg::*;
#(
    parameter int ROWS         = 32,
    parameter int DATA_W       = 32,
    parameter int WRITE_CYCLES = 7,
    parameter int ROW_W        = $clog2(ROWS),
    parameter int PC_W         = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              busy,
    output logic              rd_block,
    output logic [DATA_W-1:0] rd_word,
    output logic [PC_W-1:0]   flip_cnt
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        logic [ROWS-1:0][DATA_W-1:0] mem;
        sb_state_e                   state;
        logic [CNT_W-1:0]            cnt;
        logic [ROW_W-1:0]            row;
        logic [DATA_W-1:0]           mask;
    } sb_st_t;

    sb_st_t st_d, st_q;
    logic [DATA_W-1:0] diff;
    logic              any_diff;

    assign diff     = st_q.mem[wr_row] ^ wr_data;
    assign any_diff = |diff;

    srf_popcount #(.W(DATA_W), .CW(PC_W)) u_pop (.vec(diff), .cnt(flip_cnt));

    always_comb begin
        st_d = st_q;
        if (st_q.state == SB_PROG) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.mem[st_q.row] = st_q.mem[st_q.row] ^ st_q.mask;
                st_d.state         = SB_IDLE;
                st_d.cnt           = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        if (wr_en && any_diff) begin
            st_d.state = SB_PROG;
            st_d.cnt   = CNT_W'(WRITE_CYCLES);
            st_d.row   = wr_row;
            st_d.mask  = diff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        busy     = (st_q.state == SB_PROG);
        rd_block = busy && (rd_row != st_q.row);
        rd_word  = st_q.mem[rd_row];
        if (busy && (rd_row == st_q.row)) rd_word = st_q.mem[rd_row] ^ st_q.mask;
    end

    assert_accept_only_idle_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (st_q.state == SB_IDLE));
    assert_zero_diff_no_occupy_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !any_diff) |=> (st_q.state == SB_IDLE));
    assert_diff_occupies_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && any_diff) |=> (busy && st_q.cnt == CNT_W'(WRITE_CYCLES)));
    assert_retire_commits_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && st_q.cnt == CNT_W'(1)) |=>
            (!busy && st_q.mem[$past(st_q.row)] == $past(st_q.mem[st_q.row] ^ st_q.mask)));
endmodule

// File: rtl/subbank_regfile.sv
module subbank_regfile #(
    parameter int NUM_SUBBANKS = 4,
    parameter int NUM_THREADS  = 4,
    parameter int NUM_REGS     = 32,
    parameter int DATA_W       = 32,
    parameter int WRITE_CYCLES = 7
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_valid,
    output logic                            wr_ready,
    input  logic [$clog2(NUM_THREADS)-1:0]  wr_tid,
    input  logic [$clog2(NUM_REGS)-1:0]     wr_idx,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            rd_valid,
    output logic                            rd_ready,
    input  logic [$clog2(NUM_THREADS)-1:0]  rd_tid,
    input  logic [$clog2(NUM_REGS)-1:0]     rd_idx,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            rd_data_valid,
    output logic                            flip_valid,
    output logic [$clog2(DATA_W+1)-1:0]     flip_count
);
    localparam int SB_W  = $clog2(NUM_SUBBANKS);
    localparam int ROWS  = NUM_THREADS * NUM_REGS / NUM_SUBBANKS;
    localparam int ROW_W = $clog2(ROWS);
    localparam int PC_W  = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              rd_vld;
        logic              flip_vld;
        logic [PC_W-1:0]   flip_cnt;
    } out_st_t;

    out_st_t out_d, out_q;

    logic [SB_W-1:0]  wr_sb, rd_sb;
    logic [ROW_W-1:0] wr_row, rd_row;
    logic             wr_fire, rd_fire;

    logic [NUM_SUBBANKS-1:0]             sb_busy, sb_block, sb_wr_en;
    logic [NUM_SUBBANKS-1:0][DATA_W-1:0] sb_rd_word;
    logic [NUM_SUBBANKS-1:0][PC_W-1:0]   sb_flip;

    srf_addr_map #(.NUM_SUBBANKS(NUM_SUBBANKS), .NUM_THREADS(NUM_THREADS), .NUM_REGS(NUM_REGS))
        u_wr_map (.tid(wr_tid), .idx(wr_idx), .sb(wr_sb), .row(wr_row));
    srf_addr_map #(.NUM_SUBBANKS(NUM_SUBBANKS), .NUM_THREADS(NUM_THREADS), .NUM_REGS(NUM_REGS))
        u_rd_map (.tid(rd_tid), .idx(rd_idx), .sb(rd_sb), .row(rd_row));

    for (genvar s = 0; s < NUM_SUBBANKS; s++) begin : g_sb
        assign sb_wr_en[s] = wr_fire && (wr_sb == SB_W'(s));
        srf_subbank #(
            .ROWS(ROWS), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES),
            .ROW_W(ROW_W), .PC_W(PC_W)
        ) u_sb (
            .clk(clk), .rst(rst),
            .wr_en(sb_wr_en[s]), .wr_row(wr_row), .wr_data(wr_data),
            .rd_row(rd_row),
            .busy(sb_busy[s]), .rd_block(sb_block[s]),
            .rd_word(sb_rd_word[s]), .flip_cnt(sb_flip[s])
        );
    end

    always_comb begin
        wr_ready = !sb_busy[wr_sb];
        rd_ready = !sb_block[rd_sb];
        wr_fire  = wr_valid && wr_ready;
        rd_fire  = rd_valid && rd_ready;

        out_d          = out_q;
        out_d.rd_vld   = rd_fire;
        out_d.flip_vld = wr_fire;
        if (rd_fire) out_d.rd_data  = sb_rd_word[rd_sb];
        if (wr_fire) out_d.flip_cnt = sb_flip[wr_sb];
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign rd_data       = out_q.rd_data;
    assign rd_data_valid = out_q.rd_vld;
    assign flip_valid    = out_q.flip_vld;
    assign flip_count    = out_q.flip_cnt;

    assert_read_latency_R5: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> rd_data_valid);
    assert_flip_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> flip_valid);
    assert_flip_range_R4: assert property (@(posedge clk) disable iff (rst)
        flip_valid |-> (flip_count <= PC_W'(DATA_W)));
    assert_no_cross_block_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !sb_busy[rd_sb]) |-> rd_ready);
    assert_one_capture_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sb_wr_en));
endmodule

// File: tb/subbank_regfile_bench.sv
`timescale 1ns/1ps
module subbank_regfile_bench;
    localparam int NSB = 4, NT = 4, NR = 32, DW = 32, WC = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid, rd_valid;
    logic [1:0]  wr_tid, rd_tid;
    logic [4:0]  wr_idx, rd_idx;
    logic [31:0] wr_data;
    logic        wr_ready, rd_ready, rd_data_valid, flip_valid;
    logic [31:0] rd_data;
    logic [5:0]  flip_count;

    int n_chk = 0, n_fail = 0;

    logic [31:0] m_mem [NT][NR];
    int          m_cnt [NSB];
    int          m_pt  [NSB];
    int          m_pi  [NSB];
    logic [31:0] m_pd  [NSB];

    always #2.5 clk = ~clk;

    subbank_regfile #(
        .NUM_SUBBANKS(NSB), .NUM_THREADS(NT), .NUM_REGS(NR),
        .DATA_W(DW), .WRITE_CYCLES(WC)
    ) u_subbank_regfile (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tid(wr_tid),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_tid(rd_tid),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_data_valid(rd_data_valid),
        .flip_valid(flip_valid), .flip_count(flip_count)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check ready in-cycle,
    // advance the model, check registered outputs at the next falling edge.
    task automatic step(input bit wv, input int wt, input int wi, input logic [31:0] wd,
                        input bit rv, input int rt, input int ri);
        int          wsb, rsb, eflip;
        bit          exp_wr, exp_rr, fwd, wfire, rfire;
        logic [31:0] erd;
        string       rtag;
        wr_valid = wv; wr_tid = 2'(wt); wr_idx = 5'(wi); wr_data = wd;
        rd_valid = rv; rd_tid = 2'(rt); rd_idx = 5'(ri);
        #1;
        wsb    = wi % NSB;
        rsb    = ri % NSB;
        exp_wr = (m_cnt[wsb] == 0);
        fwd    = (m_cnt[rsb] != 0) && (m_pt[rsb] == rt) && (m_pi[rsb] == ri);
        exp_rr = (m_cnt[rsb] == 0) || fwd;
        chk(wr_ready == exp_wr, exp_wr ? "R1" : "R2", "wr_ready", 64'(wr_ready), 64'(exp_wr));
        chk(rd_ready == exp_rr, exp_rr ? "R8" : "R7", "rd_ready", 64'(rd_ready), 64'(exp_rr));
        wfire = wv && exp_wr;
        rfire = rv && exp_rr;
        erd   = fwd ? m_pd[rsb] : m_mem[rt][ri];
        rtag  = fwd ? "R6" : "R9";
        eflip = $countones(m_mem[wt][wi] ^ wd);
        for (int s = 0; s < NSB; s++) begin
            if (m_cnt[s] != 0) begin
                m_cnt[s]--;
                if (m_cnt[s] == 0) m_mem[m_pt[s]][m_pi[s]] = m_pd[s];
            end
        end
        if (wfire && eflip != 0) begin
            m_cnt[wsb] = WC; m_pt[wsb] = wt; m_pi[wsb] = wi; m_pd[wsb] = wd;
        end
        @(negedge clk);
        chk(rd_data_valid == rfire, "R5", "rd_data_valid", 64'(rd_data_valid), 64'(rfire));
        if (rfire) chk(rd_data == erd, rtag, "rd_data", 64'(rd_data), 64'(erd));
        chk(flip_valid == wfire, "R4", "flip_valid", 64'(flip_valid), 64'(wfire));
        if (wfire) chk(flip_count == 6'(eflip), (eflip == 0) ? "R3" : "R4", "flip_count",
                       64'(flip_count), 64'(eflip));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++)
            for (int r = 0; r < NR; r++) m_mem[t][r] = '0;
        for (int s = 0; s < NSB; s++) begin
            m_cnt[s] = 0; m_pt[s] = 0; m_pi[s] = 0; m_pd[s] = '0;
        end
        rst = 1'b1;
        wr_valid = 0; rd_valid = 0; wr_tid = 0; rd_tid = 0;
        wr_idx = 0; rd_idx = 0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset leaves outputs quiet, buffers idle, contents zero
        chk(rd_data_valid == 0, "R10", "rd_data_valid after reset", 64'(rd_data_valid), 0);
        chk(flip_valid == 0, "R10", "flip_valid after reset", 64'(flip_valid), 0);
        chk(wr_ready == 1, "R10", "wr_ready after reset", 64'(wr_ready), 1);
        chk(rd_ready == 1, "R10", "rd_ready after reset", 64'(rd_ready), 1);
        @(negedge clk);
        step(0, 0, 0, '0, 1, 3, 17);                       // zero contents, R10
        // changing write to t1 r5 (subbank 1), then forwarding read
        step(1, 1, 5, 32'h0000_00FF, 0, 0, 0);
        step(1, 1, 9, 32'h1, 1, 1, 5);                     // write blocked, forward hit
        step(0, 0, 0, '0, 1, 1, 9);                        // same subbank, other row: stall
        step(0, 0, 0, '0, 1, 2, 5);                        // other thread, same subbank: stall
        step(0, 0, 0, '0, 1, 1, 6);                        // other subbank: free
        idle(WC);
        step(0, 0, 0, '0, 1, 1, 5);                        // committed value
        // zero-change write, then immediate write to the same subbank
        step(1, 1, 5, 32'h0000_00FF, 0, 0, 0);
        step(1, 1, 13, 32'hA5A5_0000, 0, 0, 0);
        idle(WC + 1);
        for (int i = 0; i < 3000; i++) begin
            int          wt, wi, rt, ri;
            logic [31:0] wd;
            wt = int'($urandom % NT);  wi = int'($urandom % NR);
            wd = ($urandom % 4 == 0) ? m_mem[wt][wi] : 32'($urandom);
            if ($urandom % 3 == 0) begin rt = m_pt[wi % NSB]; ri = m_pi[wi % NSB]; end
            else begin rt = int'($urandom % NT); ri = int'($urandom % NR); end
            step(($urandom % 3) != 0, wt, wi, wd, ($urandom % 2) == 0, rt, ri);
        end
        idle(WC + 1);
        for (int r = 0; r < NR; r++) step(0, 0, 0, '0, 1, 2, r);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule